// File: doc/BRIEF.md
# Range-Checked RAM with Undefined-Word Tracking

This block is a single-clock synchronous RAM of 2^A words, each D bits wide, that keeps a "defined" flag beside every word. Synchronous reset clears every flag, so after reset each location is undefined. The data array itself is not reset. Reading a location whose flag is still clear returns zero and raises an undefined-read error instead of returning stale contents.

One store port carries two kinds of store, chosen by `st_signed`. The unsigned kind accepts only values from 0 to 2^D-1. The signed kind accepts only values from -(2^(D-1)) to 2^(D-1)-1 and stores the two's complement form. The store value comes in as a (D+1)-bit magnitude with a separate negative flag, so values outside either range can be presented and rejected. The address ports are A+1 bits wide, and any address with bit A set lies beyond the top word.

A store that fails the address or value check leaves the memory and its flags untouched. Every store and every read produces a one-cycle response with error flags on the cycle after it is requested.

Top module: `guarded_ram`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears every defined flag and every response output. Afterwards every in-range read reports `rd_undef_err`=1 until that word is stored.
- R2: An address with bit A set (any value above 2^A-1) on either port raises the address error flag of that port's response and changes no word or flag. A read response with an address error has `rd_data`=0.
- R3: With `st_signed`=0, a store is accepted only if `st_neg`=0 and `st_mag` < 2^D. The word stored is `st_mag[D-1:0]`. Any other value raises `st_range_err` and leaves the word unchanged.
- R4: With `st_signed`=1, a store is accepted only if the value (negative when `st_neg`=1) lies in -(2^(D-1))..2^(D-1)-1. The word stored is the low D bits of its two's complement. Any other value raises `st_range_err` and leaves the word unchanged.
- R5: A read of an in-range word whose defined flag is clear gives `rd_undef_err`=1 and `rd_data`=0. A read of a defined word gives the stored word with both read error flags low.
- R6: `rd_ack` is high for exactly the cycle after a cycle with `rd_en`=1. `rd_data` and the read error flags are meaningful only then, and they are zero otherwise.
- R7: When a store and a read address the same word in one cycle, the read returns the word and the defined state from before that store.
- R8: On either port an address error takes priority: when the address flag is set, the range or undefined flag of the same response is 0.
- R9: `st_ack` is high for exactly the cycle after a cycle with `st_en`=1, and it carries that store's error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| st_en | input | 1 | Store request |
| st_signed | input | 1 | 0: unsigned store check, 1: signed store check |
| st_addr | input | A+1 | Store address |
| st_neg | input | 1 | Store value is negative |
| st_mag | input | D+1 | Store value magnitude |
| rd_en | input | 1 | Read request |
| rd_addr | input | A+1 | Read address |
| st_ack | output | 1 | Store response strobe |
| st_addr_err | output | 1 | Store address was out of range |
| st_range_err | output | 1 | Store value did not fit the selected kind |
| rd_ack | output | 1 | Read response strobe |
| rd_data | output | D | Read word, zero on error |
| rd_addr_err | output | 1 | Read address was out of range |
| rd_undef_err | output | 1 | Read word was never stored |

## Verification
The main function is tried with unsigned stores at the top value and one past it, with negative values presented to the unsigned kind, and with signed stores at both ends of the signed range and one step beyond each. These patterns show whether each kind applies its own limit and whether a rejected store really left the word alone. Out-of-range addresses whose low bits alias a real word show whether a rejected access can reach that word. A store and a read to the same word in one cycle, first on an undefined word and then on a defined one, show whether the read sees the old contents and the old defined state.

// File: rtl/guarded_ram_pkg.sv
package guarded_ram_pkg;
    typedef enum logic {
        KIND_UNSIGNED = 1'b0,
        KIND_SIGNED   = 1'b1
    } store_kind_e;
endpackage

// File: rtl/gr_store_check.sv
module gr_store_check #(
    parameter int DATA_W = 8
) (
    input  guarded_ram_pkg::store_kind_e kind,
    input  logic                         neg,
    input  logic [DATA_W:0]              mag,
    output logic                         fits,
    output logic [DATA_W-1:0]            word
);
    localparam logic [DATA_W:0] POS_MAX = (DATA_W+1)'((2 ** (DATA_W-1)) - 1);
    localparam logic [DATA_W:0] NEG_MAX = (DATA_W+1)'(2 ** (DATA_W-1));

    logic [DATA_W:0] twos;

    always_comb begin
        twos = ~mag + 1'b1;
        if (kind == guarded_ram_pkg::KIND_UNSIGNED) begin
            fits = !neg && !mag[DATA_W];
            word = mag[DATA_W-1:0];
        end else begin
            fits = neg ? (mag <= NEG_MAX) : (mag <= POS_MAX);
            word = neg ? twos[DATA_W-1:0] : mag[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/gr_array.sv
module gr_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] w_idx,
    input  logic [DATA_W-1:0] w_word,
    input  logic              re,
    input  logic [ADDR_W-1:0] r_idx,
    output logic [DATA_W-1:0] r_word,
    output logic              r_def
);
    localparam int DEPTH = 2 ** ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0]  defined;
        logic [DATA_W-1:0] r_word;
        logic              r_def;
    } arr_state_t;

    arr_state_t s_d, s_q;
    logic [DATA_W-1:0] mem [DEPTH];

    always_comb begin
        s_d = s_q;
        if (re) begin
            s_d.r_word = mem[r_idx];
            s_d.r_def  = s_q.defined[r_idx];
        end
        if (we) begin
            s_d.defined[w_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we && !rst) begin
            mem[w_idx] <= w_word;
        end
    end

    assign r_word = s_q.r_word;
    assign r_def  = s_q.r_def;

    // R1
    defined_only_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((s_q.defined & $past(s_q.defined)) == $past(s_q.defined)));
endmodule

// File: rtl/guarded_ram.sv
module guarded_ram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_en,
    input  logic              st_signed,
    input  logic [ADDR_W:0]   st_addr,
    input  logic              st_neg,
    input  logic [DATA_W:0]   st_mag,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   rd_addr,
    output logic              st_ack,
    output logic              st_addr_err,
    output logic              st_range_err,
    output logic              rd_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_addr_err,
    output logic              rd_undef_err
);
    import guarded_ram_pkg::*;

    typedef struct packed {
        logic st_ack;
        logic st_aerr;
        logic st_rerr;
        logic rd_ack;
        logic rd_aerr;
    } resp_t;

    resp_t r_d, r_q;

    store_kind_e       kind;
    logic              val_fits;
    logic [DATA_W-1:0] val_word;
    logic              st_oor, rd_oor;
    logic              mem_we, mem_re;
    logic [DATA_W-1:0] arr_word;
    logic              arr_def;

    assign kind   = store_kind_e'(st_signed);
    assign st_oor = st_addr[ADDR_W];
    assign rd_oor = rd_addr[ADDR_W];

    gr_store_check #(.DATA_W(DATA_W)) u_check (
        .kind (kind),
        .neg  (st_neg),
        .mag  (st_mag),
        .fits (val_fits),
        .word (val_word)
    );

    always_comb begin
        r_d         = '0;
        r_d.st_ack  = st_en;
        r_d.st_aerr = st_en && st_oor;
        r_d.st_rerr = st_en && !st_oor && !val_fits;
        r_d.rd_ack  = rd_en;
        r_d.rd_aerr = rd_en && rd_oor;
        mem_we      = st_en && !st_oor && val_fits;
        mem_re      = rd_en && !rd_oor;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    gr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk    (clk),
        .rst    (rst),
        .we     (mem_we),
        .w_idx  (st_addr[ADDR_W-1:0]),
        .w_word (val_word),
        .re     (mem_re),
        .r_idx  (rd_addr[ADDR_W-1:0]),
        .r_word (arr_word),
        .r_def  (arr_def)
    );

    assign st_ack       = r_q.st_ack;
    assign st_addr_err  = r_q.st_aerr;
    assign st_range_err = r_q.st_rerr;
    assign rd_ack       = r_q.rd_ack;
    assign rd_addr_err  = r_q.rd_aerr;
    assign rd_undef_err = r_q.rd_ack && !r_q.rd_aerr && !arr_def;
    assign rd_data      = (r_q.rd_ack && !r_q.rd_aerr && arr_def) ? arr_word : '0;

    // R6
    rd_ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        rd_ack |-> $past(rd_en));

    // R9
    st_ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        st_ack |-> $past(st_en));

    // R8
    rd_flag_priority_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_addr_err, rd_undef_err}));

    // R8
    st_flag_priority_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({st_addr_err, st_range_err}));

    // R6
    rd_flags_need_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_err || rd_undef_err || (rd_data != '0)) |-> rd_ack);

    // R2
    rd_oor_no_data_chk: assert property (@(posedge clk) disable iff (rst)
        rd_addr_err |-> (rd_data == '0));
endmodule

// File: tb/sim_guarded_ram.sv
module sim_guarded_ram;
    localparam int A = 4;
    localparam int D = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         st_en = 1'b0, st_signed = 1'b0, st_neg = 1'b0;
    logic [A:0]   st_addr = '0;
    logic [D:0]   st_mag = '0;
    logic         rd_en = 1'b0;
    logic [A:0]   rd_addr = '0;
    logic         st_ack, st_addr_err, st_range_err;
    logic         rd_ack, rd_addr_err, rd_undef_err;
    logic [D-1:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    guarded_ram #(.ADDR_W(A), .DATA_W(D)) u0 (
        .clk(clk), .rst(rst),
        .st_en(st_en), .st_signed(st_signed), .st_addr(st_addr),
        .st_neg(st_neg), .st_mag(st_mag),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .st_ack(st_ack), .st_addr_err(st_addr_err), .st_range_err(st_range_err),
        .rd_ack(rd_ack), .rd_data(rd_data),
        .rd_addr_err(rd_addr_err), .rd_undef_err(rd_undef_err)
    );

    // op: 0 unsigned store, 1 signed store, 2 read
    // ea: expected address error, eb: expected range/undefined error
    typedef struct packed {
        logic [1:0] op;
        logic [4:0] addr;
        logic       neg;
        logic [8:0] mag;
        logic       ea;
        logic       eb;
        logic [7:0] data;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{2'd2, 5'd3,  1'b0, 9'd0,   1'b0, 1'b1, 8'h00}, // R1 undefined after reset
        '{2'd0, 5'd3,  1'b0, 9'd200, 1'b0, 1'b0, 8'h00}, // R3 accept
        '{2'd2, 5'd3,  1'b0, 9'd0,   1'b0, 1'b0, 8'hC8}, // R5 defined read
        '{2'd0, 5'd4,  1'b0, 9'd255, 1'b0, 1'b0, 8'h00}, // R3 top value
        '{2'd0, 5'd5,  1'b0, 9'd256, 1'b0, 1'b1, 8'h00}, // R3 one past top
        '{2'd2, 5'd5,  1'b0, 9'd0,   1'b0, 1'b1, 8'h00}, // R3 rejected left undefined
        '{2'd0, 5'd6,  1'b1, 9'd1,   1'b0, 1'b1, 8'h00}, // R3 negative rejected
        '{2'd1, 5'd6,  1'b1, 9'd128, 1'b0, 1'b0, 8'h00}, // R4 signed minimum
        '{2'd2, 5'd6,  1'b0, 9'd0,   1'b0, 1'b0, 8'h80}, // R4 two's complement
        '{2'd1, 5'd7,  1'b0, 9'd127, 1'b0, 1'b0, 8'h00}, // R4 signed maximum
        '{2'd1, 5'd7,  1'b0, 9'd128, 1'b0, 1'b1, 8'h00}, // R4 one past maximum
        '{2'd2, 5'd7,  1'b0, 9'd0,   1'b0, 1'b0, 8'h7F}, // R4 word unchanged
        '{2'd1, 5'd8,  1'b1, 9'd129, 1'b0, 1'b1, 8'h00}, // R4 one below minimum
        '{2'd0, 5'd16, 1'b1, 9'd300, 1'b1, 1'b0, 8'h00}, // R2 R8 address beats range
        '{2'd2, 5'd16, 1'b0, 9'd0,   1'b1, 1'b0, 8'h00}, // R2 R8 read beyond top
        '{2'd2, 5'd0,  1'b0, 9'd0,   1'b0, 1'b1, 8'h00}, // R2 alias word untouched
        '{2'd2, 5'd4,  1'b0, 9'd0,   1'b0, 1'b0, 8'hFF}, // R5 top value back
        '{2'd1, 5'd15, 1'b1, 9'd1,   1'b0, 1'b0, 8'h00}, // R4 minus one
        '{2'd2, 5'd15, 1'b0, 9'd0,   1'b0, 1'b0, 8'hFF}  // R4 minus one read
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_store(input logic sgn, input logic [A:0] a, input logic n, input logic [D:0] m);
        st_en = 1'b1; st_signed = sgn; st_addr = a; st_neg = n; st_mag = m;
    endtask

    task automatic idle();
        st_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset st_ack", {31'd0, st_ack}, 0);
        check("R1 reset rd outputs", {21'd0, rd_ack, rd_data, rd_addr_err, rd_undef_err}, 0);

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].op == 2'd2) begin
                rd_en = 1'b1; rd_addr = TBL[i].addr;
            end else begin
                do_store(TBL[i].op[0], TBL[i].addr, TBL[i].neg, TBL[i].mag);
            end
            @(negedge clk);
            idle();
            if (TBL[i].op == 2'd2) begin
                check($sformatf("R6 vec%0d rd_ack", i), {31'd0, rd_ack}, 1);
                check($sformatf("R2 R5 vec%0d rd flags", i), {30'd0, rd_addr_err, rd_undef_err},
                      {30'd0, TBL[i].ea, TBL[i].eb});
                check($sformatf("R5 vec%0d rd_data", i), {24'd0, rd_data}, {24'd0, TBL[i].data});
                check($sformatf("R9 vec%0d no st_ack", i), {31'd0, st_ack}, 0);
            end else begin
                check($sformatf("R9 vec%0d st_ack", i), {31'd0, st_ack}, 1);
                check($sformatf("R3 R4 vec%0d st flags", i), {30'd0, st_addr_err, st_range_err},
                      {30'd0, TBL[i].ea, TBL[i].eb});
                check($sformatf("R6 vec%0d no rd_ack", i), {31'd0, rd_ack}, 0);
            end
        end

        // R6 idle cycle: responses drop
        @(negedge clk);
        check("R6 idle outputs", {21'd0, rd_ack, rd_data, rd_addr_err, rd_undef_err}, 0);

        // R7 same-cycle store and read to an undefined word
        do_store(1'b0, 5'd9, 1'b0, 9'd33);
        rd_en = 1'b1; rd_addr = 5'd9;
        @(negedge clk);
        idle();
        check("R7 undefined before same-cycle store", {31'd0, rd_undef_err}, 1);
        check("R7 data zero", {24'd0, rd_data}, 0);
        rd_en = 1'b1; rd_addr = 5'd9;
        @(negedge clk);
        idle();
        check("R7 stored word visible next", {23'd0, rd_undef_err, rd_data}, 33);

        // R7 same-cycle store and read to a defined word
        do_store(1'b1, 5'd3, 1'b0, 9'd10);
        rd_en = 1'b1; rd_addr = 5'd3;
        @(negedge clk);
        idle();
        check("R7 old data returned", {24'd0, rd_data}, 32'hC8);
        rd_en = 1'b1; rd_addr = 5'd3;
        @(negedge clk);
        idle();
        check("R7 new data afterwards", {24'd0, rd_data}, 10);

        // R2 out-of-range store aliasing word 3 leaves it alone
        do_store(1'b0, 5'd19, 1'b0, 9'd99);
        @(negedge clk);
        idle();
        check("R2 alias store flagged", {31'd0, st_addr_err}, 1);
        rd_en = 1'b1; rd_addr = 5'd3;
        @(negedge clk);
        idle();
        check("R2 alias word unchanged", {24'd0, rd_data}, 10);

        // R1 reset clears defined flags
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_en = 1'b1; rd_addr = 5'd3;
        @(negedge clk);
        idle();
        check("R1 undefined after second reset", {23'd0, rd_undef_err, rd_data}, 32'h100);
        rd_en = 1'b1; rd_addr = 5'd4;
        @(negedge clk);
        idle();
        check("R1 other word undefined", {31'd0, rd_undef_err}, 1);

        @(negedge clk);
        finish_run();
    end
endmodule